// File: doc/BRIEF.md
# Coalescing Store Buffer

This block sits between a cache and the next memory level and takes stores off the processor's critical path. Each accepted store is held in a small ring of entries. An entry carries one block address, a data slot for every word of the block and a bit per word that marks which slots hold written data. The downstream write port then empties the entries one at a time, while the processor keeps issuing stores.

A store whose block already sits in a pending entry is folded into that entry, so several stores to one block use a single slot and a single downstream transaction. This keeps the buffer from filling as quickly. Two kinds of entry never take a merge. The first is any entry made by a store flagged as I/O. The second is the oldest entry, which is the one offered on the drain port. The store port drops its ready signal only when every slot is occupied and the incoming store has no entry it may join.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `dr_valid_o` = 0, `full_o` = 0, `st_ready_o` = 1.
- R2: A store that does not merge takes the youngest free slot with block address `st_addr_i[ADDR_W-1:OFF_W]` (OFF_W = log2(WORDS)). Its word mask has only bit `st_addr_i[OFF_W-1:0]` set, and that word holds `st_data_i`.
- R3: A non-I/O store whose block matches a pending entry that is neither I/O nor the oldest sets that entry's mask bit for its word and overwrites that word. It allocates no slot.
- R4: A store with `st_io_i` = 1 always allocates its own slot, and no later store merges into an I/O entry.
- R5: `dr_valid_o` is 1 exactly when at least one entry is pending. Entries leave oldest-first, one per cycle with `dr_valid_o` and `dr_ready_i` both high.
- R6: The oldest entry (the one shown on the drain port) accepts no merge. A matching store allocates a new slot instead.
- R7: `st_ready_o` is 0 only when all DEPTH slots are occupied and the store cannot merge (I/O, or no eligible match).
- R8: `full_o` is 1 exactly when all DEPTH slots are occupied.
- R9: While `dr_valid_o` = 1 and `dr_ready_i` = 0, `dr_addr_o`, `dr_mask_o` and the masked words of `dr_data_o` hold. Each transaction presents the block address and the mask of words written; word w sits at `dr_data_o[w*DATA_W +: DATA_W]`.
- R10: A store offered while `st_ready_o` = 0 leaves the buffer contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request |
| st_ready_o | output | 1 | Store accepted this cycle when high with st_valid_i |
| st_addr_i | input | ADDR_W | Word address of the store |
| st_data_i | input | DATA_W | Store data |
| st_io_i | input | 1 | Store targets I/O space; never merged |
| full_o | output | 1 | All slots occupied |
| dr_valid_o | output | 1 | Oldest entry offered downstream |
| dr_ready_i | input | 1 | Downstream takes the offered entry |
| dr_addr_o | output | ADDR_W-OFF_W | Block address of the offered entry |
| dr_mask_o | output | WORDS | Written-word mask of the offered entry |
| dr_data_o | output | WORDS*DATA_W | Word data of the offered entry |

## Verification
The bench builds the buffer with DEPTH = 4, WORDS = 4, DATA_W = 8 and a 6-bit address. It confines random stores to three blocks, so merges, head-match refusals, I/O slots and a full buffer all happen within a few cycles. Directed sequences fill the ring, refuse a store when it is full, and show that the head and I/O entries do not absorb merges. Random sweeps then vary drain readiness from stalled to free-running and I/O density from none to frequent. The bench checks every cycle against an arithmetic queue model.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_MERGE = 2'd1,
    ACT_ALLOC = 2'd2
  } st_act_e;
endpackage

// File: rtl/mwb_match.sv
module mwb_match #(
  parameter int DEPTH = 4,
  parameter int BLK_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][BLK_W-1:0] blk_i,
  input  logic [DEPTH-1:0]            elig_i,
  input  logic [BLK_W-1:0]            st_blk_i,
  output logic                        hit_o,
  output logic [PTR_W-1:0]            hit_idx_o
);
  logic [DEPTH-1:0] eq;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = elig_i[g] && (blk_i[g] == st_blk_i);
  end

  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit_o     = 1'b1;
        hit_idx_o = PTR_W'(i);
      end
    end
  end
endmodule

// File: rtl/mwb_ring.sv
module mwb_ring #(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic             full_o
);
  logic [PTR_W:0] cnt_q;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_o <= '0;
      tail_o <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_o <= inc(tail_o);
      if (pop_i)  head_o <= inc(head_o);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign full_o = (cnt_q == (PTR_W+1)'(DEPTH));
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int DEPTH  = 4,
  localparam int OFF_W = $clog2(WORDS),
  localparam int BLK_W = ADDR_W - OFF_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    st_valid_i,
  output logic                    st_ready_o,
  input  logic [ADDR_W-1:0]       st_addr_i,
  input  logic [DATA_W-1:0]       st_data_i,
  input  logic                    st_io_i,
  output logic                    full_o,
  output logic                    dr_valid_o,
  input  logic                    dr_ready_i,
  output logic [BLK_W-1:0]        dr_addr_o,
  output logic [WORDS-1:0]        dr_mask_o,
  output logic [WORDS*DATA_W-1:0] dr_data_o
);
  import mwb_pkg::*;
  localparam int PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0][BLK_W-1:0]             blk_q;
  logic [DEPTH-1:0][WORDS-1:0]             mask_q;
  logic [DEPTH-1:0][WORDS-1:0][DATA_W-1:0] data_q;
  logic [DEPTH-1:0]                        vld_q, io_q;

  logic [PTR_W-1:0] head, tail, hit_idx;
  logic             hit, push, pop;
  logic [DEPTH-1:0] head_oh, elig;
  logic [BLK_W-1:0] st_blk;
  logic [OFF_W-1:0] st_off;
  st_act_e          act;

  assign st_blk = st_addr_i[ADDR_W-1:OFF_W];
  assign st_off = st_addr_i[OFF_W-1:0];

  // head is owned by the drain port; I/O entries never coalesce
  always_comb begin
    head_oh       = '0;
    head_oh[head] = 1'b1;
  end
  assign elig = vld_q & ~io_q & ~head_oh;

  mwb_match #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_match (
    .blk_i    (blk_q),
    .elig_i   (elig),
    .st_blk_i (st_blk),
    .hit_o    (hit),
    .hit_idx_o(hit_idx)
  );

  assign st_ready_o = (!st_io_i && hit) || !full_o;

  always_comb begin
    act = ACT_NONE;
    if (st_valid_i) begin
      if (!st_io_i && hit) act = ACT_MERGE;
      else if (!full_o)    act = ACT_ALLOC;
    end
  end

  assign dr_valid_o = vld_q[head];
  assign pop        = dr_valid_o && dr_ready_i;
  assign push       = (act == ACT_ALLOC);

  mwb_ring #(.DEPTH(DEPTH)) u_ring (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(push),
    .pop_i (pop),
    .head_o(head),
    .tail_o(tail),
    .full_o(full_o)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        io_q[g]   <= 1'b0;
        blk_q[g]  <= '0;
        mask_q[g] <= '0;
        data_q[g] <= '0;
      end else begin
        if (pop && head == PTR_W'(g)) vld_q[g] <= 1'b0;
        if (push && tail == PTR_W'(g)) begin
          vld_q[g]          <= 1'b1;
          io_q[g]           <= st_io_i;
          blk_q[g]          <= st_blk;
          mask_q[g]         <= WORDS'(1) << st_off;
          data_q[g][st_off] <= st_data_i;
        end
        if (act == ACT_MERGE && hit_idx == PTR_W'(g)) begin
          mask_q[g][st_off] <= 1'b1;
          data_q[g][st_off] <= st_data_i;
        end
      end
    end
  end

  assign dr_addr_o = blk_q[head];
  assign dr_mask_o = mask_q[head];
  assign dr_data_o = data_q[head];
endmodule

// File: rtl/merge_wbuf_chk.sv
module merge_wbuf_chk #(
  parameter int BLK_W = 8,
  parameter int WORDS = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             st_valid_i,
  input logic             st_ready_o,
  input logic             full_o,
  input logic             dr_valid_o,
  input logic             dr_ready_i,
  input logic [BLK_W-1:0] dr_addr_o,
  input logic [WORDS-1:0] dr_mask_o
);
  a_r7_ready_with_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_o |-> st_ready_o);

  a_r8_full_not_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> dr_valid_o);

  a_r2_first_alloc_one_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dr_valid_o && st_valid_i && st_ready_o) |=> (dr_valid_o && $countones(dr_mask_o) == 1));

  a_r9_drain_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dr_valid_o && !dr_ready_i) |=> (dr_valid_o && $stable(dr_addr_o)));

  a_r6_head_no_merge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dr_valid_o && !dr_ready_i) |=> $stable(dr_mask_o));

  a_r10_reject_keeps_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && !st_ready_o && !dr_ready_i) |=> full_o);
endmodule

bind merge_wbuf merge_wbuf_chk #(.BLK_W(BLK_W), .WORDS(WORDS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .st_valid_i(st_valid_i),
  .st_ready_o(st_ready_o),
  .full_o    (full_o),
  .dr_valid_o(dr_valid_o),
  .dr_ready_i(dr_ready_i),
  .dr_addr_o (dr_addr_o),
  .dr_mask_o (dr_mask_o)
);

// File: tb/merge_wbuf_tb.sv
module merge_wbuf_tb;
  localparam int ADDR_W = 6, DATA_W = 8, WORDS = 4, DEPTH = 4;
  localparam int OFF_W = $clog2(WORDS), BLK_W = ADDR_W - OFF_W;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic st_valid_i = 1'b0, st_io_i = 1'b0, dr_ready_i = 1'b0;
  logic [ADDR_W-1:0] st_addr_i = '0;
  logic [DATA_W-1:0] st_data_i = '0;
  logic st_ready_o, full_o, dr_valid_o;
  logic [BLK_W-1:0] dr_addr_o;
  logic [WORDS-1:0] dr_mask_o;
  logic [WORDS*DATA_W-1:0] dr_data_o;

  always #5 clk = ~clk;

  merge_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .st_valid_i(st_valid_i), .st_ready_o(st_ready_o), .st_addr_i(st_addr_i),
    .st_data_i(st_data_i), .st_io_i(st_io_i), .full_o(full_o),
    .dr_valid_o(dr_valid_o), .dr_ready_i(dr_ready_i), .dr_addr_o(dr_addr_o),
    .dr_mask_o(dr_mask_o), .dr_data_o(dr_data_o)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  string phase = "";

  int m_cnt = 0;
  int m_blk[DEPTH+1];
  int m_mask[DEPTH+1];
  int m_data[DEPTH+1][WORDS];
  bit m_io[DEPTH+1];

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  task automatic step(bit v, int blk, int off, int d, bit io, bit rdy);
    int hit, old;
    bit exp_rdy;
    @(negedge clk);
    st_valid_i = v;
    st_addr_i  = ADDR_W'((blk << OFF_W) | off);
    st_data_i  = DATA_W'(d);
    st_io_i    = io;
    dr_ready_i = rdy;
    #1;
    hit = -1;
    for (int i = 1; i < m_cnt; i++) if (!m_io[i] && m_blk[i] == blk) hit = i;
    exp_rdy = (!io && hit >= 0) || (m_cnt < DEPTH);
    chk("R7 st_ready_o", int'(st_ready_o), int'(exp_rdy));
    chk("R8 full_o", int'(full_o), int'(m_cnt == DEPTH));
    chk("R5 dr_valid_o", int'(dr_valid_o), int'(m_cnt > 0));
    if (m_cnt > 0) begin
      chk("R2 dr_addr_o", int'(dr_addr_o), m_blk[0]);
      chk("R3 dr_mask_o", int'(dr_mask_o), m_mask[0]);
      for (int w = 0; w < WORDS; w++)
        if (m_mask[0][w]) chk("R9 dr_data_o word", int'(dr_data_o[w*DATA_W +: DATA_W]), m_data[0][w]);
    end
    old = m_cnt;
    // R10: a refused store leaves the model untouched
    if (v && exp_rdy) begin
      if (!io && hit >= 0) begin           // R3 merge
        m_mask[hit] |= (1 << off);
        m_data[hit][off] = d;
      end else begin                       // R2/R4/R6 allocate
        m_blk[m_cnt] = blk;
        m_mask[m_cnt] = 1 << off;
        m_data[m_cnt][off] = d;
        m_io[m_cnt] = io;
        m_cnt++;
      end
    end
    if (rdy && old > 0) begin              // R5 oldest leaves
      for (int i = 0; i < DEPTH; i++) begin
        m_blk[i] = m_blk[i+1];
        m_mask[i] = m_mask[i+1];
        m_io[i] = m_io[i+1];
        for (int w = 0; w < WORDS; w++) m_data[i][w] = m_data[i+1][w];
      end
      m_cnt--;
    end
  endtask

  task automatic drain_all();
    for (int k = 0; k < DEPTH + 2; k++) step(0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog [%s] actual=timeout expected=finish", phase);
    if (!done) begin
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    phase = "R1 reset";
    #1;
    chk("R1 dr_valid_o", int'(dr_valid_o), 0);
    chk("R1 full_o", int'(full_o), 0);
    chk("R1 st_ready_o", int'(st_ready_o), 1);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    phase = "R6 head no merge";
    step(1, 1, 0, 11, 0, 0);
    step(1, 1, 1, 12, 0, 0);   // matches head only: new slot
    step(1, 1, 2, 13, 0, 0);   // merges into second slot
    drain_all();

    phase = "R4 io no merge";
    step(1, 3, 0, 20, 0, 0);
    step(1, 2, 0, 21, 1, 0);
    step(1, 2, 1, 22, 0, 0);   // io entry refuses, new slot
    step(1, 2, 2, 23, 1, 0);   // io always allocates (buffer full now)
    step(1, 2, 3, 24, 0, 0);   // full, merges into non-io entry
    drain_all();

    phase = "R10 rejected store";
    for (int b = 0; b < DEPTH; b++) step(1, b + 4, b % WORDS, 30 + b, 0, 0);
    step(1, 9, 1, 99, 0, 0);   // full, no match: refused
    step(1, 5, 2, 98, 1, 0);   // full, io: refused
    step(1, 5, 3, 97, 0, 0);   // full, match non-head: merge
    drain_all();

    phase = "sweep";
    for (int rp = 0; rp < 4; rp++) begin
      for (int ip = 0; ip < 3; ip++) begin
        for (int n = 0; n < 1500; n++) begin
          bit rdy, io, v;
          rdy = (rp == 3) ? 1'b1 : (($urandom % 4) < rp);
          io  = (ip == 0) ? 1'b0 : (($urandom % (ip == 1 ? 8 : 3)) == 0);
          v   = ($urandom % 4) != 0;
          step(v, $urandom % 3, $urandom % WORDS, $urandom % 256, io, rdy);
        end
        drain_all();
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule